// File: doc/BRIEF.md
# Programmable Counter Channel Core

This block is a single channel of an up/down event counter with a 32-bit core. A front-end decoder, which is not part of this block, turns the two counter phases into a count strobe and a direction bit. This block adds everything that sits behind that decoder: a 16-bit configuration word, two preload registers, a capture register, an index input with selectable polarity, and an extra core bit that flips every time the count steps onto zero.

The configuration word arrives as two byte writes on the same port, low byte first, and takes effect once the high byte lands. Preload, capture, count enable and count disable each have their own trigger selection. The choices are an index leading or trailing edge, the count stepping onto zero, or a soft pulse. The output pin has four selectable sources and a polarity control. The channel halts whenever the run bit in the configuration word is cleared. Bits 6:4 and bit 0 are stored and exported on `mode_o` for the front-end decoder. They have no effect inside this block.

Top module: `ctr_channel`

## Requirements
- R1: `mode_o` changes only after two byte writes. The first byte becomes bits 7:0 and the second becomes bits 15:8. It stays 0 after reset until the second byte is written.
- R2: When the run bit (bit 15) is 0, on every clock the count, the zero-toggle bit, the count enable and the preload pointer are forced to 0. Steps and all triggers are ignored. Preload and capture registers keep their contents.
- R3: Re-writing the configuration with the run bit set while the channel runs leaves the count unchanged.
- R4: A count step (run, enabled, `cnt_step`) adds 1 when `cnt_up` is 1 and subtracts 1 otherwise. The count wraps between 0 and 2^32-1, and each wrap gives a one-cycle wrap pulse.
- R5: `bit32_o` toggles on each step that lands the count on 0.
- R6: Bits 14:13 select the output source: 0 gives count bit 31, 1 gives `bit32_o`, 2 is active while the count is 0, and 3 gives the wrap pulse. Bit 7 set inverts the pin.
- R7: Bit 12 set makes the index input active-low. Leading and trailing edges are taken after this inversion.
- R8: Bits 11:10 select the preload trigger: 0 or 3 gives the soft pulse only, 1 adds the index leading edge, and 2 adds a step landing on zero. A preload wins over a count step in the same cycle.
- R9: Bit 9 = 0 captures the count on `soft_lat` only. Bit 9 = 1 also captures on an index leading edge.
- R10: With bit 8 = 0, counting is enabled one cycle after a configuration write with run set. With bit 8 = 1, counting is enabled by an index leading edge.
- R11: Bits 3:2 select the count disable: 0 never disables, 1 disables on an index trailing edge while enabled, and 2 disables when a step lands on zero.
- R12: Bit 1 = 0 always preloads from register 0. Bit 1 = 1 alternates the preloads between register 0 and register 1, starting with register 0 after a halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Configuration byte strobe |
| mode_byte | input | 8 | Configuration byte, low byte first |
| pre_wr | input | 1 | Preload register write strobe |
| pre_idx | input | 1 | Preload register select (0 or 1) |
| pre_val | input | CW | Preload write data |
| soft_pre | input | 1 | Soft preload pulse |
| soft_lat | input | 1 | Soft capture pulse |
| cnt_step | input | 1 | Count strobe from the front-end decoder |
| cnt_up | input | 1 | Count direction, 1 = up |
| index_in | input | 1 | Index input |
| mode_o | output | 16 | Current configuration word |
| count_o | output | CW | Count core |
| bit32_o | output | 1 | Zero-toggle core bit |
| latch_o | output | CW | Capture register |
| enabled_o | output | 1 | Count enable state |
| out_pin_o | output | 1 | Output pin |

## Verification
A stuck enable shows up within one step as a count that does not move, or as a count that moves while the channel should be gated. A preload pointer that is out of phase shows up on the very next soft preload, because the count loads the wrong register. Errors in the zero-toggle bit or in the wrap pulse appear on `bit32_o` or on the pin in the cycle right after the step that lands on zero or wraps. A halt that fails to clear state shows up as a non-zero count, or as an enable that is already set when the channel restarts.

// File: rtl/ctr_channel.sv
module ctr_channel #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_wr,
  input  logic [7:0]    mode_byte,
  input  logic          pre_wr,
  input  logic          pre_idx,
  input  logic [CW-1:0] pre_val,
  input  logic          soft_pre,
  input  logic          soft_lat,
  input  logic          cnt_step,
  input  logic          cnt_up,
  input  logic          index_in,
  output logic [15:0]   mode_o,
  output logic [CW-1:0] count_o,
  output logic          bit32_o,
  output logic [CW-1:0] latch_o,
  output logic          enabled_o,
  output logic          out_pin_o
);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [7:0]    lo_q;
  logic          phase_q, cfg_q;
  logic [15:0]   mode_q;
  logic          idx_q;
  logic [CW-1:0] cnt_q, pre0_q, pre1_q, lat_q;
  logic          b32_q, en_q, wrap_q, ptr_q;

  wire commit = mode_wr & phase_q;

  wire       run = mode_q[15];
  wire [1:0] om  = mode_q[14:13];
  wire       xp  = mode_q[12];
  wire [1:0] pl  = mode_q[11:10];
  wire       lat = mode_q[9];
  wire       cet = mode_q[8];
  wire       op  = mode_q[7];
  wire [1:0] cd  = mode_q[3:2];
  wire       plm = mode_q[1];

  wire idx_p = index_in ^ xp;
  wire lead  = idx_p & ~idx_q;
  wire trail = ~idx_p & idx_q;

  wire [CW-1:0] nxt  = cnt_up ? cnt_q + ONE : cnt_q - ONE;
  wire wrap_w        = cnt_up ? (cnt_q == CMAX) : (cnt_q == '0);
  wire step_raw      = run & en_q & cnt_step;
  wire ext_pre       = run & (soft_pre | ((pl == 2'd1) & lead));
  wire zero_hit      = step_raw & (nxt == '0) & ~ext_pre;
  wire pre_fire      = ext_pre | ((pl == 2'd2) & zero_hit);
  wire [CW-1:0] psel = (plm & ptr_q) ? pre1_q : pre0_q;
  wire lat_fire      = run & (soft_lat | (lat & lead));
  wire dis           = ((cd == 2'd1) & trail & en_q) | ((cd == 2'd2) & zero_hit);
  wire arm           = (cfg_q & ~cet) | (cet & lead);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '0;
      phase_q <= 1'b0;
      mode_q  <= '0;
      cfg_q   <= 1'b0;
    end else begin
      cfg_q <= commit;
      if (mode_wr) begin
        if (!phase_q) begin
          lo_q    <= mode_byte;
          phase_q <= 1'b1;
        end else begin
          mode_q  <= {mode_byte, lo_q};
          phase_q <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= 1'b0;
    else        idx_q <= idx_p;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre0_q <= '0;
      pre1_q <= '0;
    end else if (pre_wr) begin
      if (pre_idx) pre1_q <= pre_val;
      else         pre0_q <= pre_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lat_q <= '0;
    else if (lat_fire) lat_q <= cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      b32_q  <= 1'b0;
      en_q   <= 1'b0;
      wrap_q <= 1'b0;
      ptr_q  <= 1'b0;
    end else if (!run) begin
      cnt_q  <= '0;
      b32_q  <= 1'b0;
      en_q   <= 1'b0;
      wrap_q <= 1'b0;
      ptr_q  <= 1'b0;
    end else begin
      if (pre_fire)      cnt_q <= psel;
      else if (step_raw) cnt_q <= nxt;
      if (zero_hit) b32_q <= ~b32_q;
      wrap_q <= step_raw & wrap_w & ~ext_pre;
      if (dis)      en_q <= 1'b0;
      else if (arm) en_q <= 1'b1;
      if (pre_fire & plm) ptr_q <= ~ptr_q;
    end
  end

  logic src;
  always_comb begin
    case (om)
      2'd0:    src = cnt_q[CW-1];
      2'd1:    src = b32_q;
      2'd2:    src = (cnt_q == '0);
      default: src = wrap_q;
    endcase
  end

  assign out_pin_o = src ^ op;
  assign mode_o    = mode_q;
  assign count_o   = cnt_q;
  assign bit32_o   = b32_q;
  assign latch_o   = lat_q;
  assign enabled_o = en_q;

  assert_halt_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0 && !b32_q && !en_q && !ptr_q));

  assert_wrap_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_q && !$past(pre_fire)) |-> (cnt_q == '0 || cnt_q == CMAX));

  assert_b32_on_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && !$stable(b32_q)) |-> $past(zero_hit));

  assert_latch_on_trig_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lat_q) |-> $past(lat_fire));

  assert_enable_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> ($past(cfg_q) || $past(lead)));
endmodule

// File: tb/ctr_channel_bench.sv
module ctr_channel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wr = 1'b0;
  logic [7:0]  mode_byte = '0;
  logic        pre_wr = 1'b0;
  logic        pre_idx = 1'b0;
  logic [31:0] pre_val = '0;
  logic        soft_pre = 1'b0, soft_lat = 1'b0;
  logic        cnt_step = 1'b0, cnt_up = 1'b0;
  logic        index_in = 1'b0;
  logic [15:0] mode_o;
  logic [31:0] count_o, latch_o;
  logic        bit32_o, enabled_o, out_pin_o;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  ctr_channel u_ctr_channel (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_byte(mode_byte),
    .pre_wr(pre_wr), .pre_idx(pre_idx), .pre_val(pre_val),
    .soft_pre(soft_pre), .soft_lat(soft_lat), .cnt_step(cnt_step),
    .cnt_up(cnt_up), .index_in(index_in), .mode_o(mode_o),
    .count_o(count_o), .bit32_o(bit32_o), .latch_o(latch_o),
    .enabled_o(enabled_o), .out_pin_o(out_pin_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wr_mode(input logic [15:0] w);
    mode_wr = 1'b1; mode_byte = w[7:0]; tick();
    mode_byte = w[15:8]; tick();
    mode_wr = 1'b0; tick();
  endtask

  task automatic wr_pre(input logic sel, input logic [31:0] v);
    pre_wr = 1'b1; pre_idx = sel; pre_val = v; tick(); pre_wr = 1'b0;
  endtask

  task automatic soft_p(); soft_pre = 1'b1; tick(); soft_pre = 1'b0; endtask
  task automatic soft_l(); soft_lat = 1'b1; tick(); soft_lat = 1'b0; endtask
  task automatic steps(input int n, input logic up);
    cnt_step = 1'b1; cnt_up = up; repeat (n) tick(); cnt_step = 1'b0;
  endtask
  task automatic set_idx(input logic v); index_in = v; tick(); endtask

  task automatic t_reset();
    chk("R2 reset count", count_o, 0);
    chk("R2 reset bit32", {31'd0, bit32_o}, 0);
    chk("R2 reset enabled", {31'd0, enabled_o}, 0);
    chk("R1 reset mode", {16'd0, mode_o}, 0);
    chk("R6 reset pin", {31'd0, out_pin_o}, 0);
  endtask

  task automatic t_basic();
    mode_wr = 1'b1; mode_byte = 8'h00; tick(); mode_wr = 1'b0; tick();
    chk("R1 one byte no commit", {16'd0, mode_o}, 0);
    mode_wr = 1'b1; mode_byte = 8'h80; tick(); mode_wr = 1'b0;
    chk("R1 commit", {16'd0, mode_o}, 32'h8000);
    tick();
    chk("R10 enable on config", {31'd0, enabled_o}, 1);
    steps(5, 1'b1);
    chk("R4 count up", count_o, 5);
    steps(2, 1'b0);
    chk("R4 count down", count_o, 3);
    wr_mode(16'h8000);
    chk("R3 rewrite keeps count", count_o, 3);
  endtask

  task automatic t_wrap_out();
    wr_pre(1'b0, 32'd1); soft_p();
    chk("R8 soft preload", count_o, 1);
    steps(1, 1'b0);
    chk("R5 bit32 toggles at zero", {31'd0, bit32_o}, 1);
    wr_mode(16'hE000);
    steps(1, 1'b0);
    chk("R4 wrap down", count_o, 32'hFFFF_FFFF);
    chk("R6 wrap pulse on pin", {31'd0, out_pin_o}, 1);
    tick();
    chk("R4 wrap pulse one cycle", {31'd0, out_pin_o}, 0);
    wr_mode(16'h8080);
    chk("R6 bit31 inverted", {31'd0, out_pin_o}, 0);
    wr_mode(16'h8000);
    chk("R6 bit31", {31'd0, out_pin_o}, 1);
    wr_mode(16'hA000);
    chk("R6 bit32 source", {31'd0, out_pin_o}, 1);
    wr_mode(16'hC000);
    chk("R6 zero source nonzero", {31'd0, out_pin_o}, 0);
    steps(1, 1'b1);
    chk("R4 wrap up", count_o, 0);
    chk("R5 bit32 toggles back", {31'd0, bit32_o}, 0);
    chk("R6 zero source active", {31'd0, out_pin_o}, 1);
  endtask

  task automatic t_halt();
    wr_pre(1'b0, 32'h55); soft_p(); soft_l();
    chk("R9 soft capture", latch_o, 32'h55);
    wr_mode(16'h0000);
    chk("R2 halt count", count_o, 0);
    chk("R2 halt enabled", {31'd0, enabled_o}, 0);
    chk("R2 halt keeps capture", latch_o, 32'h55);
    steps(3, 1'b1); soft_p();
    chk("R2 halted ignores steps", count_o, 0);
    wr_mode(16'h8000);
    soft_p();
    chk("R2 preload kept over halt", count_o, 32'h55);
  endtask

  task automatic t_index_enable();
    wr_mode(16'h0000); set_idx(1'b1);
    wr_mode(16'h9100);
    chk("R10 waits for index", {31'd0, enabled_o}, 0);
    steps(2, 1'b1);
    chk("R10 no count before index", count_o, 0);
    set_idx(1'b0);
    chk("R7 active-low leading edge enables", {31'd0, enabled_o}, 1);
    steps(2, 1'b1);
    chk("R4 counts after enable", count_o, 2);
    wr_mode(16'h9104);
    set_idx(1'b1);
    chk("R11 trailing edge disables", {31'd0, enabled_o}, 0);
    steps(1, 1'b1);
    chk("R11 no count after disable", count_o, 2);
    wr_mode(16'h8008);
    wr_pre(1'b0, 32'd2); soft_p();
    steps(2, 1'b0);
    chk("R11 zero disables", {31'd0, enabled_o}, 0);
    steps(1, 1'b0);
    chk("R11 count held at zero", count_o, 0);
  endtask

  task automatic t_preload();
    wr_mode(16'h0000); set_idx(1'b0);
    wr_pre(1'b0, 32'd100);
    wr_mode(16'h8400);
    set_idx(1'b1);
    chk("R8 index preload", count_o, 100);
    set_idx(1'b0);
    wr_pre(1'b0, 32'd200);
    wr_mode(16'h8C00);
    set_idx(1'b1);
    chk("R8 reserved ignores index", count_o, 100);
    soft_p();
    chk("R8 reserved soft works", count_o, 200);
    set_idx(1'b0);
    wr_mode(16'h8000);
    set_idx(1'b1);
    chk("R8 soft-only ignores index", count_o, 200);
    set_idx(1'b0);
    wr_mode(16'h8800);
    wr_pre(1'b0, 32'd1); soft_p();
    wr_pre(1'b0, 32'd7);
    steps(1, 1'b0);
    chk("R8 reload on zero", count_o, 7);
    chk("R5 toggle on reload zero", {31'd0, bit32_o}, 1);
    wr_pre(1'b0, 32'd50);
    cnt_step = 1'b1; cnt_up = 1'b1; soft_pre = 1'b1; tick();
    cnt_step = 1'b0; soft_pre = 1'b0;
    chk("R8 preload beats step", count_o, 50);
  endtask

  task automatic t_latch();
    wr_mode(16'h8200);
    set_idx(1'b1);
    chk("R9 index capture", latch_o, 50);
    steps(3, 1'b1);
    wr_mode(16'h8000);
    set_idx(1'b0); set_idx(1'b1);
    chk("R9 no index capture when off", latch_o, 50);
    chk("R4 count after capture", count_o, 53);
  endtask

  task automatic t_plm();
    wr_mode(16'h0000);
    wr_pre(1'b0, 32'd10); wr_pre(1'b1, 32'd20);
    wr_mode(16'h8002);
    soft_p(); chk("R12 first from reg0", count_o, 10);
    soft_p(); chk("R12 second from reg1", count_o, 20);
    soft_p(); chk("R12 third from reg0", count_o, 10);
    soft_p();
    wr_mode(16'h0000); wr_mode(16'h8002);
    soft_p(); chk("R12 pointer restarts after halt", count_o, 10);
    wr_mode(16'h8000);
    soft_p(); chk("R12 single register mode", count_o, 10);
    wr_pre(1'b0, 32'd11);
    soft_p(); chk("R12 single register again", count_o, 11);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_basic();
    t_wrap_out();
    t_halt();
    t_index_enable();
    t_preload();
    t_latch();
    t_plm();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule